// File: doc/BRIEF.md
# Byte-Lane Static RAM Behavioural Core

This block is a synthesizable stand-in for a 16-bit static memory whose control pins are all level-sensitive. A small array (256 words by default) sits behind two chip selects of opposite polarity, one active-low enable per byte lane, an active-low write strobe and an active-low output enable. The bidirectional data bus of a real part is split into a data-in bus, a data-out bus and one drive-enable per byte lane. A pad ring or a tristate wrapper can rebuild the shared bus from these signals.

A simulation clock replaces the asynchronous timing of the real device. Writes land in the array at the rising edge while a write condition holds, and the address is taken at that same edge. Reads are combinational: a lane's data and its drive-enable follow the controls and the address without waiting for a clock edge. Each byte lane decodes its own mode, so one lane can be read or written while the other stays at high impedance.

Top module: `bytelane_sram`

## Requirements
- R1: The chip is selected only while `cs_a_n` is 0 and `cs_b` is 1 at the same time. Otherwise no lane is driven (`dout_en` is 2'b00) and no byte is written, whatever `we_n`, `oe_n` and `lane_n` are.
- R2: While both bits of `lane_n` are 1 the chip is deselected. No lane is driven and no byte is written.
- R3: At a rising clock edge with the chip selected, `we_n` 0 and `lane_n[i]` 0, the byte `din` of lane i is stored at `addr`. The value of `oe_n` has no effect on this.
- R4: With the chip selected, `we_n` 1, `oe_n` 0 and `lane_n[i]` 0, lane i is driven (`dout_en[i]`=1) in the same cycle. It shows the stored byte of lane i at the current `addr`.
- R5: Lane 0 is the lower byte, bits 7:0 of `din`/`dout`, controlled by `lane_n[0]`. Lane 1 is the upper byte, bits 15:8, controlled by `lane_n[1]`.
- R6: A lane whose `lane_n` bit is 1 is neither driven nor written, even while the other lane is read or written.
- R7: With the chip selected, `we_n` 1 and `oe_n` 1, no lane is driven and nothing is written.
- R8: While a write condition is present (`we_n` 0), no lane is driven.
- R9: Reset (`rst_n` 0) clears every stored byte to 0, so a byte never written after reset reads as 0. An undriven lane presents 0 on its `dout` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock; writes take effect at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears the array |
| cs_a_n | input | 1 | Active-low chip select |
| cs_b | input | 1 | Active-high chip select |
| lane_n | input | 2 | Active-low byte-lane enables; bit 0 lower byte, bit 1 upper byte |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 8 | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data, 0 on undriven lanes |
| dout_en | output | 2 | Per-lane drive enable; 1 means the lane drives the bus |

## Verification
A wrong stored byte stays hidden until that address is read with its lane enabled. Any read of it after the faulty write edge shows the error at once on `dout`, because reads are combinational. A wrong mode decode shows up in the same cycle as a wrong `dout_en` bit. A lane written when it should have been left alone shows up only on the next read of that word. The bench therefore reads back after each disturbing stimulus and keeps addresses in a narrow range during random traffic, so that such errors surface within a few cycles.

// File: rtl/bls_pkg.sv
package bls_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } lane_mode_e;

  // Chip-level select: both selects active and at least one lane enabled.
  function automatic logic chip_on(input logic cs_a_n, input logic cs_b,
                                   input logic all_lanes_off);
    return !cs_a_n && cs_b && !all_lanes_off;
  endfunction

  // Mode of one byte lane given the chip select and the strobes.
  function automatic lane_mode_e lane_mode(input logic sel, input logic lane_off,
                                           input logic we_n, input logic oe_n);
    lane_mode_e m;
    if (!sel || lane_off) m = MODE_OFF;
    else if (!we_n)       m = MODE_WRITE;
    else if (!oe_n)       m = MODE_READ;
    else                  m = MODE_IDLE;
    return m;
  endfunction

endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic [LANES-1:0] lane_n,
  input  logic             we_n,
  input  logic             oe_n,
  output logic             chip_sel,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);

  assign chip_sel = chip_on(cs_a_n, cs_b, &lane_n);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_mode_e mode;
    assign mode       = lane_mode(chip_sel, lane_n[g], we_n, oe_n);
    assign lane_wr[g] = (mode == MODE_WRITE);
    assign lane_rd[g] = (mode == MODE_READ);
  end

endmodule

// File: rtl/bls_lane.sv
module bls_lane
  import bls_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (wr) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
  import bls_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic [LANES-1:0]  lane_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_en
);

  logic             chip_sel;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;

  bls_decode #(.LANES(LANES)) u_decode (
    .cs_a_n  (cs_a_n),
    .cs_b    (cs_b),
    .lane_n  (lane_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .chip_sel(chip_sel),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_store
    logic [LANE_W-1:0] rdata;
    bls_lane #(.DEPTH(DEPTH)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (lane_wr[g]),
      .addr (addr),
      .wdata(din[g*LANE_W +: LANE_W]),
      .rdata(rdata)
    );
    assign dout[g*LANE_W +: LANE_W] = lane_rd[g] ? rdata : '0;
  end

  assign dout_en = lane_rd;

endmodule

// File: rtl/bls_checker.sv
module bls_checker
  import bls_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LANES = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic [LANES-1:0]  lane_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [AW-1:0]     addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic [LANES-1:0]  dout_en,
  input logic [LANES-1:0]  lane_wr,
  input logic              chip_sel
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: a missing chip select silences every lane and blocks writes
  assert_cs_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_a_n || !cs_b) |-> (dout_en == '0 && lane_wr == '0));

  // R2: all lanes disabled means deselected
  assert_lanes_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_n) |-> (!chip_sel && dout_en == '0 && lane_wr == '0));

  // R7: selected but neither strobe active does nothing
  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> (dout_en == '0));

  // R8: no lane is driven during a write
  assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |-> (dout_en == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R6: a disabled lane is neither driven nor written
    assert_lane_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_n[g] |-> (!dout_en[g] && !lane_wr[g]));

    // R9: an undriven lane shows zero
    assert_undriven_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en[g] |-> (dout[g*LANE_W +: LANE_W] == '0));

    // R3: a byte written at one edge reads back at the same address next cycle
    assert_write_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(lane_wr[g]) && dout_en[g] && addr == $past(addr))
      |-> (dout[g*LANE_W +: LANE_W] == $past(din[g*LANE_W +: LANE_W])));
  end

  // oe_n is only listed so the checker sees the full control set
  logic unused_ok;
  assign unused_ok = oe_n;

endmodule

bind bytelane_sram bls_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_a_n  (cs_a_n),
  .cs_b    (cs_b),
  .lane_n  (lane_n),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .addr    (addr),
  .din     (din),
  .dout    (dout),
  .dout_en (dout_en),
  .lane_wr (lane_wr),
  .chip_sel(chip_sel)
);

// File: tb/bytelane_sram_bench.sv
`timescale 1ns/1ps
module bytelane_sram_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_a_n = 1'b1;
  logic        cs_b = 1'b0;
  logic [1:0]  lane_n = 2'b11;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] model [256];

  always #5 clk = ~clk;

  bytelane_sram u_bytelane_sram (
    .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b(cs_b), .lane_n(lane_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual en=%b data=%h expected en=%b data=%h",
               tag, act[17:16], act[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare the combinational
  // outputs against the model, then apply any write at the rising edge.
  task automatic cycle(input string tag, input logic a_n, input logic b,
                       input logic [1:0] ln, input logic w_n, input logic o_n,
                       input logic [7:0] ad, input logic [15:0] d);
    logic selected;
    logic [1:0] exp_en;
    logic [15:0] exp_d;
    @(negedge clk);
    cs_a_n = a_n; cs_b = b; lane_n = ln; we_n = w_n; oe_n = o_n; addr = ad; din = d;
    #1;
    selected = (a_n == 1'b0) && (b == 1'b1) && (ln != 2'b11);
    exp_en = 2'b00;
    exp_d  = 16'h0000;
    if (selected && w_n && !o_n) begin
      if (!ln[0]) begin exp_en[0] = 1'b1; exp_d[7:0]  = model[ad][7:0];  end
      if (!ln[1]) begin exp_en[1] = 1'b1; exp_d[15:8] = model[ad][15:8]; end
    end
    check(tag, {dout_en, dout}, {exp_en, exp_d});
    @(posedge clk);
    if (selected && !w_n) begin
      if (!ln[0]) model[ad][7:0]  = d[7:0];
      if (!ln[1]) model[ad][15:8] = d[15:8];
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] ad);
    cycle(tag, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, ad, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset outputs", {dout_en, dout}, 18'h0);
    @(negedge clk);
    rst_n = 1'b1;

    rd("R9 unwritten word 0", 8'd0);
    rd("R9 unwritten word 255", 8'd255);

    cycle("R3 write both lanes oe high", 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 8'd5, 16'hA55A);
    cycle("R8 write with oe low, no drive", 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'd6, 16'h0F0F);
    rd("R4 read word 5", 8'd5);
    rd("R4 read word 6", 8'd6);
    cycle("R5 write lower lane only", 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 8'd5, 16'h1234);
    rd("R6 upper kept after lower write", 8'd5);
    cycle("R5 write upper lane only", 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 8'd6, 16'hBEEF);
    rd("R6 lower kept after upper write", 8'd6);
    cycle("R6 read lower lane only", 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 8'd5, 16'h0000);
    cycle("R6 read upper lane only", 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 8'd6, 16'h0000);

    cycle("R1 cs_a_n high blocks write", 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 8'd5, 16'hFFFF);
    cycle("R1 cs_b low blocks write", 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'd5, 16'hFFFF);
    cycle("R1 cs_a_n high blocks read", 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 8'd5, 16'h0000);
    cycle("R1 cs_b low blocks read", 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 8'd5, 16'h0000);
    cycle("R2 lanes off blocks write", 1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 8'd5, 16'hFFFF);
    cycle("R2 lanes off blocks read", 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 8'd5, 16'h0000);
    rd("R1 R2 word 5 unchanged", 8'd5);
    cycle("R7 idle selected no drive", 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 8'd5, 16'h0000);

    cycle("R3 write top address", 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 8'd255, 16'hC3C3);
    rd("R4 read top address", 8'd255);
    rd("R9 unwritten word 200", 8'd200);

    for (int n = 0; n < 3000; n++) begin
      cycle("R4 random traffic", 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0),
            2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            8'($urandom_range(0, 7)), 16'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule